// File: doc/BRIEF.md
# Cascadable Compare-Match Timer

This block holds two 8-bit up-counters, a low half and a high half, each with its own compare register, match flag, overflow flag and toggle output. A mode bit chooses between two independent 8-bit timers and one 16-bit timer, in which the high half advances when the low half wraps. Two per-half count-enable strobes stand in for the selected count clock. A counter moves only on a cycle where its strobe is high.

Software works through a small synchronous register bus. It can preset and read the counters, set the compare values, choose the mode and the output levels, and read and clear the status flags. The block defines what happens when a bus write and a hardware event fall on the same clock edge. A control write beats a toggle. A compare write re-judges the match against the new value. A counter write cancels an overflow. A hardware flag set beats a software clear.

Register map (3-bit address): 0 control, 1 status, 2 low counter, 3 high counter, 4 low compare, 5 high compare. Addresses 6 and 7 read as zero. Control bits: 0 cascade, 1 low output level, 2 high output level, 3 low clear-on-match, 4 high clear-on-match. Bits above 4 are ignored and read as zero. Status bits: 0 low match, 1 low overflow, 2 high match, 3 high overflow.

Top module: `cascade_match_timer`

## Requirements
- R1: After reset, control, status and both counters read 0x00, both compare registers read 0xFF, and both toggle outputs are low.
- R2: In 8-bit mode (control bit 0 = 0), each counter adds one on a cycle where its own strobe is high. A counter at 0xFF wraps to 0x00 and sets its overflow flag (status bit 1 low, bit 3 high).
- R3: In cascade mode (control bit 0 = 1), the low counter runs on tick_lo. The high counter adds one only on a tick_lo cycle where the low counter wraps, and tick_hi has no effect. Status bit 3 is set only when the full 16-bit count wraps; status bit 1 is set on every low wrap.
- R4: A match is judged on a strobe cycle, against the counter value before the increment; no strobe means no match. The low match flag (bit 0) needs only the low 8 bits to be equal. In cascade mode the high match flag (bit 2) needs all 16 bits to be equal.
- R5: Each toggle output flips on its own half's match; in cascade mode only the 16-bit match flips tout_hi. In cascade mode tout_lo is held at 0.
- R6: A control write loads tout_lo from control bit 1 and tout_hi from control bit 2, and it discards any match toggle in the same cycle.
- R7: A compare write in the same cycle as a strobe judges the match against the written value, not the old one.
- R8: A counter write loads the written value. An overflow of that half in the same cycle is suppressed, and in cascade mode a written low half gives no carry.
- R9: A status bit is cleared by writing 0 to it only if it read as 1 in the most recent status read. Any status write disarms all bits. A hardware set in the same cycle wins over the clear.
- R10: With clear-on-match enabled (control bit 3 low half, bit 4 high half or whole 16-bit counter in cascade mode), the counter becomes 0x00 on the cycle after a match. That cycle ignores the strobe and raises no match or overflow.
- R11: Registers sit at the addresses listed above. Writes read back unchanged, except that unused control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clears) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| tick_lo | input | 1 | Count enable for the low half |
| tick_hi | input | 1 | Count enable for the high half (8-bit mode only) |
| tout_lo | output | 1 | Low half toggle output |
| tout_hi | output | 1 | High half toggle output |

## Verification
The collisions that matter are a bus write and a counter event on the same edge. These are a control write against a toggling match, a compare write against a match, a counter write against a wrap, and a status clear against a flag set. Directed sequences first place the counter one step before the event, then issue the write on the strobe cycle and judge the result against fixed expected values. A long random phase then mixes writes near 0xFF and the compare values with random strobes. A cycle model built from the requirements predicts every read and both outputs on each cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int AW = 3;

  localparam logic [AW-1:0] AD_CTRL   = 3'd0;
  localparam logic [AW-1:0] AD_STAT   = 3'd1;
  localparam logic [AW-1:0] AD_CNT_LO = 3'd2;
  localparam logic [AW-1:0] AD_CNT_HI = 3'd3;
  localparam logic [AW-1:0] AD_CMP_LO = 3'd4;
  localparam logic [AW-1:0] AD_CMP_HI = 3'd5;

  localparam int CTRL_W    = 5;
  localparam int CB_CASC   = 0;
  localparam int CB_LVL_LO = 1;
  localparam int CB_LVL_HI = 2;

  localparam int STAT_W    = 4;
  localparam int SB_MAT_LO = 0;
  localparam int SB_OVF_LO = 1;
  localparam int SB_MAT_HI = 2;
  localparam int SB_OVF_HI = 3;

  typedef struct packed {
    logic clr_hi;
    logic clr_lo;
    logic lvl_hi;
    logic lvl_lo;
    logic casc;
  } ctrl_t;

endpackage

// File: rtl/cmt_half.sv
module cmt_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic         cnt_ld;

  always_comb begin
    wrap   = en && (cnt == TOP) && !wr && !clr;
    cnt_ld = wr || clr || en;
    if (wr)       cnt_d = wdata;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ld) cnt <= cnt_d;
  end

endmodule

// File: rtl/cmt_tout.sv
module cmt_tout (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic level,
  input  logic flip,
  output logic q
);

  logic q_d;
  logic q_en;

  always_comb begin
    q_en = load || flip;
    q_d  = load ? level : !q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic [DW-1:0]         cnt_lo,
  input  logic [DW-1:0]         cnt_hi,
  input  logic [STAT_W-1:0]     stat_set,
  output ctrl_t                 ctrl,
  output logic [STAT_W-1:0]     stat,
  output logic [1:0][DW-1:0]    cmp_eff,
  output logic [1:0]            cnt_wr,
  output logic                  ctrl_wr,
  output logic [DW-1:0]         bus_rdata
);

  logic [1:0][DW-1:0] cmp_cur;
  ctrl_t              ctrl_d;
  logic [STAT_W-1:0]  stat_d;
  logic [STAT_W-1:0]  arm_q;
  logic [STAT_W-1:0]  arm_d;
  logic [STAT_W-1:0]  clr_mask;
  logic               stat_wr;
  logic               stat_rd;

  for (genvar h = 0; h < 2; h++) begin : g_cmp
    localparam logic [AW-1:0] CMP_ADR = (h == 0) ? AD_CMP_LO : AD_CMP_HI;
    localparam logic [AW-1:0] CNT_ADR = (h == 0) ? AD_CNT_LO : AD_CNT_HI;
    logic          sel;
    logic [DW-1:0] q;

    assign sel        = bus_wr && (bus_addr == CMP_ADR);
    assign cnt_wr[h]  = bus_wr && (bus_addr == CNT_ADR);
    assign cmp_cur[h] = q;
    assign cmp_eff[h] = sel ? bus_wdata : q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '1;
      else if (sel) q <= bus_wdata;
    end
  end

  always_comb begin
    ctrl_wr  = bus_wr && (bus_addr == AD_CTRL);
    stat_wr  = bus_wr && (bus_addr == AD_STAT);
    stat_rd  = bus_rd && (bus_addr == AD_STAT);
    ctrl_d   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    clr_mask = stat_wr ? (arm_q & ~bus_wdata[STAT_W-1:0]) : '0;
    stat_d   = (stat & ~clr_mask) | stat_set;
    if (stat_wr)      arm_d = '0;
    else if (stat_rd) arm_d = stat;
    else              arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= '0;
      arm_q <= '0;
    end else begin
      stat  <= stat_d;
      arm_q <= arm_d;
    end
  end

  always_comb begin
    case (bus_addr)
      AD_CTRL:   bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
      AD_STAT:   bus_rdata = {{(DW-STAT_W){1'b0}}, stat};
      AD_CNT_LO: bus_rdata = cnt_lo;
      AD_CNT_HI: bus_rdata = cnt_hi;
      AD_CMP_LO: bus_rdata = cmp_cur[0];
      AD_CMP_HI: bus_rdata = cmp_cur[1];
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cascade_match_timer.sv
module cascade_match_timer #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [cmt_pkg::AW-1:0] bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic                   tick_lo,
  input  logic                   tick_hi,
  output logic                   tout_lo,
  output logic                   tout_hi
);
  import cmt_pkg::*;

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ctrl_t              ctrl;
  logic [STAT_W-1:0]  stat;
  logic [STAT_W-1:0]  stat_set;
  logic [1:0][DW-1:0] cmp_eff;
  logic [1:0]         cnt_wr;
  logic               ctrl_wr;
  logic [DW-1:0]      cnt_lo;
  logic [DW-1:0]      cnt_hi;
  logic               wrap_lo;
  logic               wrap_hi;
  logic               en_hi;
  logic               casc;
  logic               pclr_lo_q, pclr_hi_q, pclr_lo_d, pclr_hi_d;
  logic               clr_now_lo, clr_now_hi;
  logic               eq_lo, eq_hi;
  logic               m_lo, m_hi;
  logic [1:0]         flip;
  logic [1:0]         level;
  logic [1:0]         tq;

  cmt_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .stat_set  (stat_set),
    .ctrl      (ctrl),
    .stat      (stat),
    .cmp_eff   (cmp_eff),
    .cnt_wr    (cnt_wr),
    .ctrl_wr   (ctrl_wr),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    casc       = ctrl.casc;
    clr_now_lo = casc ? pclr_hi_q : pclr_lo_q;
    clr_now_hi = pclr_hi_q;
    en_hi      = casc ? wrap_lo : tick_hi;
  end

  cmt_half #(.W(DW)) u_half_lo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (tick_lo),
    .wr    (cnt_wr[0]),
    .wdata (bus_wdata),
    .clr   (clr_now_lo),
    .cnt   (cnt_lo),
    .wrap  (wrap_lo)
  );

  cmt_half #(.W(DW)) u_half_hi (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (en_hi),
    .wr    (cnt_wr[1]),
    .wdata (bus_wdata),
    .clr   (clr_now_hi),
    .cnt   (cnt_hi),
    .wrap  (wrap_hi)
  );

  // Match judgement: counter value before the increment against the
  // effective compare value (a same-cycle write replaces the old one).
  always_comb begin
    eq_lo = (cnt_lo == cmp_eff[0]);
    eq_hi = (cnt_hi == cmp_eff[1]);
    m_lo  = tick_lo && eq_lo && !clr_now_lo;
    if (casc) m_hi = m_lo && eq_hi && !clr_now_hi;
    else      m_hi = tick_hi && eq_hi && !clr_now_hi;
    stat_set            = '0;
    stat_set[SB_MAT_LO] = m_lo;
    stat_set[SB_OVF_LO] = wrap_lo;
    stat_set[SB_MAT_HI] = m_hi;
    stat_set[SB_OVF_HI] = wrap_hi;
    pclr_lo_d = !casc && ctrl.clr_lo && m_lo;
    pclr_hi_d = ctrl.clr_hi && m_hi;
    flip[0]   = !casc && m_lo;
    flip[1]   = m_hi;
    level[0]  = bus_wdata[CB_LVL_LO];
    level[1]  = bus_wdata[CB_LVL_HI];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pclr_lo_q <= 1'b0;
      pclr_hi_q <= 1'b0;
    end else begin
      pclr_lo_q <= pclr_lo_d;
      pclr_hi_q <= pclr_hi_d;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_tout
    cmt_tout u_tout (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .load  (ctrl_wr),
      .level (level[h]),
      .flip  (flip[h]),
      .q     (tq[h])
    );
  end

  assign tout_lo = casc ? 1'b0 : tq[0];
  assign tout_hi = tq[1];

endmodule

// File: rtl/cmt_chk.sv
module cmt_chk
  import cmt_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic              tick_lo,
  input logic              tout_lo,
  input logic              tout_hi,
  input logic [STAT_W-1:0] stat,
  input logic [DW-1:0]     cnt_lo,
  input logic              clr_now_lo
);

  logic wr_ctrl, wr_cnt_lo;
  assign wr_ctrl   = bus_wr && (bus_addr == AD_CTRL);
  assign wr_cnt_lo = bus_wr && (bus_addr == AD_CNT_LO);

  // R5: entering cascade mode forces the low output low
  a_r5_lo_quiet_in_cascade: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ctrl && bus_wdata[CB_CASC]) |=> !tout_lo);

  // R6: control write sets the high output to the written level
  a_r6_level_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ctrl |=> (tout_hi == $past(bus_wdata[CB_LVL_HI])));

  // R4: no strobe, no low match flag
  a_r4_no_match_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick_lo && !stat[SB_MAT_LO]) |=> !stat[SB_MAT_LO]);

  // R8: counter write suppresses the low overflow
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_cnt_lo && !stat[SB_OVF_LO]) |=> !stat[SB_OVF_LO]);

  // R2: low counter holds without strobe, write or clear
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!tick_lo && !wr_cnt_lo && !clr_now_lo) |=> $stable(cnt_lo));

  // R10: clear cycle lands the counter on zero
  a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clr_now_lo && !wr_cnt_lo) |=> (cnt_lo == '0));

endmodule

bind cascade_match_timer cmt_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .tick_lo    (tick_lo),
  .tout_lo    (tout_lo),
  .tout_hi    (tout_hi),
  .stat       (stat),
  .cnt_lo     (cnt_lo),
  .clr_now_lo (clr_now_lo)
);

// File: tb/cascade_match_timer_test.sv
module cascade_match_timer_test;

  logic       clk;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       tick_lo, tick_hi;
  logic       tout_lo, tout_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  cascade_match_timer #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_lo(tick_lo), .tick_hi(tick_hi), .tout_lo(tout_lo), .tout_hi(tout_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = !clk;

  // reference state
  logic [4:0] m_ctrl;
  logic [3:0] m_stat, m_arm;
  logic [7:0] m_clo, m_chi, m_plo, m_phi;
  logic       m_tlo, m_thi, m_pcl, m_pch;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] mread(logic [2:0] a);
    case (a)
      3'd0: return {3'b0, m_ctrl};
      3'd1: return {4'b0, m_stat};
      3'd2: return m_clo;
      3'd3: return m_chi;
      3'd4: return m_plo;
      3'd5: return m_phi;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string atag(logic [2:0] a);
    case (a)
      3'd1: return "R9";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4, 3'd5: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic mreset();
    m_ctrl = '0; m_stat = '0; m_arm = '0;
    m_clo = '0; m_chi = '0; m_plo = 8'hFF; m_phi = 8'hFF;
    m_tlo = 0; m_thi = 0; m_pcl = 0; m_pch = 0;
  endtask

  // one cycle of the requirement model, from the driven inputs
  task automatic mstep();
    logic casc, wlo, whi, wcl, wch, wct, wst, rst_rd;
    logic [7:0] elo, ehi;
    logic clo_now, chi_now, wrap_lo, wrap_hi, en_hi, mlo, mhi;
    logic [3:0] clr, old_stat;
    casc = m_ctrl[0];
    wlo = bus_wr && bus_addr == 3'd2; whi = bus_wr && bus_addr == 3'd3;
    wcl = bus_wr && bus_addr == 3'd4; wch = bus_wr && bus_addr == 3'd5;
    wct = bus_wr && bus_addr == 3'd0; wst = bus_wr && bus_addr == 3'd1;
    rst_rd = bus_rd && bus_addr == 3'd1;
    elo = wcl ? bus_wdata : m_plo;
    ehi = wch ? bus_wdata : m_phi;
    clo_now = casc ? m_pch : m_pcl;
    chi_now = m_pch;
    wrap_lo = tick_lo && m_clo == 8'hFF && !wlo && !clo_now;
    en_hi   = casc ? wrap_lo : tick_hi;
    wrap_hi = en_hi && m_chi == 8'hFF && !whi && !chi_now;
    mlo = tick_lo && m_clo == elo && !clo_now;
    mhi = casc ? (mlo && m_chi == ehi && !chi_now) : (tick_hi && m_chi == ehi && !chi_now);
    old_stat = m_stat;
    clr = wst ? (m_arm & ~bus_wdata[3:0]) : 4'h0;
    m_stat = (m_stat & ~clr) | {wrap_hi, mhi, wrap_lo, mlo};
    if (wst) m_arm = '0; else if (rst_rd) m_arm = old_stat;
    if (wct) begin m_tlo = bus_wdata[1]; m_thi = bus_wdata[2]; end
    else begin m_thi = m_thi ^ mhi; m_tlo = m_tlo ^ (!casc && mlo); end
    if (wlo) m_clo = bus_wdata; else if (clo_now) m_clo = 8'h00; else if (tick_lo) m_clo = m_clo + 8'd1;
    if (whi) m_chi = bus_wdata; else if (chi_now) m_chi = 8'h00; else if (en_hi) m_chi = m_chi + 8'd1;
    m_pcl = !casc && m_ctrl[3] && mlo;
    m_pch = m_ctrl[4] && mhi;
    if (wcl) m_plo = bus_wdata;
    if (wch) m_phi = bus_wdata;
    if (wct) m_ctrl = bus_wdata[4:0];
  endtask

  task automatic cyc_a(logic wr, logic rd, logic [2:0] a, logic [7:0] d, logic tl, logic th);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_lo = tl; tick_hi = th;
    #1;
    if (rd) chk(atag(a), bus_rdata, mread(a));
    chk("R5", tout_lo, m_ctrl[0] ? 1'b0 : m_tlo);
    chk("R6", tout_hi, m_thi);
  endtask

  task automatic cyc_b();
    mstep();
    @(negedge clk);
  endtask

  task automatic cyc(logic wr, logic rd, logic [2:0] a, logic [7:0] d, logic tl, logic th);
    cyc_a(wr, rd, a, d, tl, th);
    cyc_b();
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    cyc(1, 0, a, d, 0, 0);
  endtask

  task automatic tick(logic tl, logic th);
    cyc(0, 0, 3'd0, 8'h00, tl, th);
  endtask

  task automatic rexp(string tag, logic [2:0] a, logic [7:0] lit);
    cyc_a(0, 1, a, 8'h00, 0, 0);
    chk(tag, bus_rdata, lit);
    cyc_b();
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; tick_lo = 0; tick_hi = 0;
    mreset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rexp("R1", 3'd0, 8'h00); rexp("R1", 3'd1, 8'h00);
    rexp("R1", 3'd2, 8'h00); rexp("R1", 3'd3, 8'h00);
    rexp("R1", 3'd4, 8'hFF); rexp("R1", 3'd5, 8'hFF);
    chk("R1", {tout_hi, tout_lo}, 2'b00);

    // R2 8-bit wrap of the low half
    wreg(3'd2, 8'hFE); tick(1, 0); tick(1, 0);
    rexp("R2", 3'd2, 8'h00); rexp("R2", 3'd3, 8'h00);
    rexp("R2", 3'd1, 8'h03);
    chk("R5", tout_lo, 1'b1);
    wreg(3'd1, 8'h00); rexp("R9", 3'd1, 8'h00);

    // R3 cascade carry and 16-bit wrap
    wreg(3'd4, 8'h10); wreg(3'd5, 8'h10); wreg(3'd0, 8'h01);
    wreg(3'd2, 8'hFF); wreg(3'd3, 8'hFF); tick(1, 1);
    rexp("R3", 3'd2, 8'h00); rexp("R3", 3'd3, 8'h00); rexp("R3", 3'd1, 8'h0A);
    chk("R5", tout_lo, 1'b0);
    tick(0, 1); tick(0, 1); tick(0, 1);
    rexp("R3", 3'd3, 8'h00);
    wreg(3'd1, 8'h00);

    // R4 full 16-bit match, then low-only match
    wreg(3'd2, 8'h05); wreg(3'd3, 8'h10); wreg(3'd4, 8'h05); tick(1, 0);
    rexp("R4", 3'd1, 8'h05);
    chk("R4", tout_hi, 1'b1);
    wreg(3'd1, 8'h00);
    wreg(3'd2, 8'h05); wreg(3'd3, 8'h11); tick(1, 0);
    rexp("R4", 3'd1, 8'h01);
    chk("R4", tout_hi, 1'b1);

    // R6 control write beats a match toggle
    wreg(3'd0, 8'h00); wreg(3'd2, 8'h05);
    cyc(1, 0, 3'd0, 8'h00, 1, 0);
    chk("R6", tout_lo, 1'b0);

    // R7 compare write in the match cycle
    wreg(3'd4, 8'h20); wreg(3'd2, 8'h20);
    cyc(1, 0, 3'd4, 8'h30, 1, 0);
    chk("R7", tout_lo, 1'b0);
    cyc(1, 0, 3'd4, 8'h21, 1, 0);
    chk("R7", tout_lo, 1'b1);

    // R8 counter write during a wrap
    cyc(0, 1, 3'd1, 8'h00, 0, 0); wreg(3'd1, 8'h00);
    wreg(3'd2, 8'hFF); cyc(1, 0, 3'd2, 8'h55, 1, 0);
    rexp("R8", 3'd2, 8'h55); rexp("R8", 3'd1, 8'h00);

    // R9 armed clear loses to a same-cycle set; unarmed clear ignored
    wreg(3'd2, 8'h21); tick(1, 0);
    rexp("R9", 3'd1, 8'h01);
    wreg(3'd4, 8'h22);
    cyc(1, 0, 3'd1, 8'h00, 1, 0);
    wreg(3'd1, 8'h00);
    rexp("R9", 3'd1, 8'h01);
    wreg(3'd1, 8'h00);
    rexp("R9", 3'd1, 8'h00);

    // R10 clear-on-match, strobe ignored in the clear cycle
    wreg(3'd0, 8'h08); wreg(3'd4, 8'h30); wreg(3'd2, 8'h30);
    tick(1, 0); tick(1, 0);
    rexp("R10", 3'd2, 8'h00);

    // R11 map readback
    wreg(3'd5, 8'hA5); rexp("R11", 3'd5, 8'hA5);
    wreg(3'd0, 8'hFF); rexp("R11", 3'd0, 8'h1F);
    rexp("R11", 3'd6, 8'h00);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic wr, rd, tl, th;
      logic [2:0] a;
      logic [7:0] d;
      wr = ($urandom % 4) == 0;
      rd = ($urandom % 2) == 0;
      a  = 3'($urandom % 7);
      tl = ($urandom % 3) != 0;
      th = ($urandom % 2) == 0;
      case ($urandom % 5)
        0: d = 8'hFF;
        1: d = 8'hFE;
        2: d = 8'h00;
        3: d = m_clo;
        default: d = 8'($urandom);
      endcase
      if (wr && a == 3'd0) d = d & 8'h1F;
      if (wr && a == 3'd1 && ($urandom % 2) == 0) begin
        cyc(0, 1, 3'd1, 8'h00, tl, th);
      end
      cyc(wr, rd, a, d, tl, th);
    end

    finish_up();
  end

endmodule